// File: doc/BRIEF.md
# Shared-Column Time-to-Digital Readout Sequencer

This block is the digital controller of a single-slope time-to-digital readout that one converter shares across a group of memory-array columns. For every column it discharges the integrating capacitor, opens the integrate gate, and counts clock cycles until a threshold comparator reports the crossing. The count is inversely proportional to the column current. The analog integrator and comparator sit outside the block. The comparator output arrives asynchronously and is synchronized inside the block.

A start pulse begins a sweep that converts every column of the group in ascending order. Each result carries the column index and two flags. One flag marks a conversion that ended at the programmable limit `count_max`, where the current was too low. The other marks a crossing within the first integration cycle, which gives a zero count and means the current was too high. Each result waits on a valid/ready handshake. The next column is not started until the consumer accepts the result. A done pulse closes the sweep.

The FSM has five states. `ST_IDLE` waits for start. `ST_DISCHARGE` resets the capacitor for a fixed number of cycles. `ST_INTEGRATE` counts until the comparator event or the limit. `ST_REPORT` holds the result until it is accepted. `ST_DONE` is a one-cycle end-of-sweep marker. The transitions are as follows:
- idle to discharge on start;
- discharge to integrate when the discharge timer expires;
- integrate to report on a comparator event or on the limit;
- report to discharge on acceptance when more columns remain;
- report to done on acceptance of the last column;
- done to idle unconditionally.

Top module: `tdc_column_sequencer`

## Requirements
- R1: A synchronous reset, whether at power-up or mid-sweep, puts the block in idle on the next clock. In idle `discharge`=1, `integrate`=0, `col_sel`=0, `res_valid`=0 and `sweep_done`=0.
- R2: A start pulse sampled in idle begins a sweep. The sweep converts columns 0 to NUM_COLS-1 strictly in ascending order. `col_sel` shows the column being converted, and `res_col` equals that column while its result is valid.
- R3: Before every integration, `discharge`=1 and `integrate`=0 for exactly DISCHARGE_CYCLES cycles. `discharge` and `integrate` are never both 1 in the same cycle, and `integrate` is 1 only during integration.
- R4: Integration cycle 0 is the first cycle with `integrate`=1. The comparator passes through a two-flop synchronizer. If it rises during integration cycle i, with 1 <= i <= count_max, then `integrate` stays high for i+3 cycles and the reported count is i with both flags 0. The two-cycle synchronizer latency is removed from the count.
- R5: A comparator rise during integration cycle 0 gives `res_count`=0 with `res_overrange`=1 and `res_timeout`=0.
- R6: If no comparator rise occurs by integration cycle count_max, `integrate` stays high for count_max+3 cycles. The result is then `res_count`=count_max with `res_timeout`=1 and `res_overrange`=0. A rise in cycle count_max itself is a normal result.
- R7: `res_valid`, `res_count`, `res_col` and both flags stay stable until `res_ready` is sampled high. `discharge` stays 1 while the result waits. The next column's discharge begins the cycle after acceptance.
- R8: `sweep_done` is a single-cycle pulse in the cycle after the last column's result is accepted. In that cycle `col_sel` is already 0, and the block then returns to idle.
- R9: A start pulse while a sweep is active has no effect. The sweep still produces exactly NUM_COLS results and one done pulse.
- R10: `count_max` may be any value up to 2^CNT_W-1. A full-scale result is reported without the internal counter wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a sweep when sampled in idle |
| count_max | input | CNT_W | Limit on the count; held constant during a sweep |
| cmp_async | input | 1 | Comparator output, asynchronous, high once threshold crossed |
| res_ready | input | 1 | Consumer accepts the held result |
| col_sel | output | $clog2(NUM_COLS) | Column routed to the converter |
| discharge | output | 1 | Capacitor discharge switch on |
| integrate | output | 1 | Integrate gate on |
| res_valid | output | 1 | Result held and available |
| res_count | output | CNT_W | Cycle count of the conversion |
| res_col | output | $clog2(NUM_COLS) | Column of the held result |
| res_timeout | output | 1 | Conversion ended at count_max |
| res_overrange | output | 1 | Comparator fired in the first integration cycle |
| sweep_done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The bench aims at the counting edges. It drives comparator rises in integration cycles 0 and 1, at count_max itself, at count_max+1, and not at all. A design that mishandles the synchronizer latency would be off by two in every count or would miss the overrange case. A design that gets the limit comparison wrong would either report count_max+1 or flag a legal result as a timeout. A full-scale limit of 255 exposes an internal counter that is too narrow, because it wraps and never times out. Stalled handshakes, start pulses inside integration and reporting, and a reset in the middle of a sweep target a design that advances columns early, restarts a sweep, or leaves the gates in an unsafe state.

// File: rtl/tdc_seq_pkg.sv
package tdc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISCHARGE,
        ST_INTEGRATE,
        ST_REPORT,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/tdc_sync_chain.sv
module tdc_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/tdc_up_counter.sv
module tdc_up_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (clr)     q <= '0;
        else if (en) q <= q + 1'b1;
    end
endmodule

// File: rtl/tdc_column_sequencer.sv
module tdc_column_sequencer
    import tdc_seq_pkg::*;
#(
    parameter int NUM_COLS         = 8,
    parameter int CNT_W            = 8,
    parameter int DISCHARGE_CYCLES = 4,
    parameter int SYNC_STAGES      = 2,
    localparam int COL_W           = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count_max,
    input  logic             cmp_async,
    input  logic             res_ready,
    output logic [COL_W-1:0] col_sel,
    output logic             discharge,
    output logic             integrate,
    output logic             res_valid,
    output logic [CNT_W-1:0] res_count,
    output logic [COL_W-1:0] res_col,
    output logic             res_timeout,
    output logic             res_overrange,
    output logic             sweep_done
);
    localparam int RAW_W = CNT_W + 2;
    localparam int DIS_W = $clog2(DISCHARGE_CYCLES + 1);

    seq_state_t state_q, state_nx;

    logic [COL_W-1:0] col_q;
    logic [RAW_W-1:0] raw_cnt;
    logic [DIS_W-1:0] dis_cnt;
    logic             cmp_hit;
    logic             dis_last;
    logic             at_limit;
    logic             last_col;
    logic             accept;
    logic [CNT_W-1:0] count_q;
    logic [COL_W-1:0] rcol_q;
    logic             tout_q;
    logic             ovr_q;

    tdc_sync_chain #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cmp_async),
        .sync_out (cmp_hit)
    );

    tdc_up_counter #(.W(DIS_W)) i_dis_timer (
        .clk (clk),
        .clr (rst || (state_q != ST_DISCHARGE)),
        .en  (state_q == ST_DISCHARGE),
        .q   (dis_cnt)
    );

    tdc_up_counter #(.W(RAW_W)) i_int_counter (
        .clk (clk),
        .clr (rst || (state_q != ST_INTEGRATE)),
        .en  (state_q == ST_INTEGRATE),
        .q   (raw_cnt)
    );

    assign dis_last = (dis_cnt == DIS_W'(DISCHARGE_CYCLES - 1));
    assign at_limit = (raw_cnt == ({2'b00, count_max} + RAW_W'(SYNC_STAGES)));
    assign last_col = (col_q == COL_W'(NUM_COLS - 1));
    assign accept   = (state_q == ST_REPORT) && res_ready;

    // next-state selection
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:      if (start)                 state_nx = ST_DISCHARGE;
            ST_DISCHARGE: if (dis_last)              state_nx = ST_INTEGRATE;
            ST_INTEGRATE: if (cmp_hit || at_limit)   state_nx = ST_REPORT;
            ST_REPORT:    if (res_ready)             state_nx = last_col ? ST_DONE : ST_DISCHARGE;
            ST_DONE:                                 state_nx = ST_IDLE;
            default:                                 state_nx = ST_IDLE;
        endcase
    end

    // state register, column index and result capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
            count_q <= '0;
            rcol_q  <= '0;
            tout_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (accept) col_q <= last_col ? '0 : col_q + 1'b1;
            if (state_q == ST_INTEGRATE) begin
                if (cmp_hit) begin
                    rcol_q <= col_q;
                    tout_q <= 1'b0;
                    if (raw_cnt <= RAW_W'(SYNC_STAGES)) begin
                        count_q <= '0;
                        ovr_q   <= 1'b1;
                    end else begin
                        count_q <= CNT_W'(raw_cnt - RAW_W'(SYNC_STAGES));
                        ovr_q   <= 1'b0;
                    end
                end else if (at_limit) begin
                    rcol_q  <= col_q;
                    count_q <= count_max;
                    tout_q  <= 1'b1;
                    ovr_q   <= 1'b0;
                end
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        discharge  = 1'b1;
        integrate  = 1'b0;
        res_valid  = 1'b0;
        sweep_done = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_DISCHARGE: ;
            ST_INTEGRATE: begin discharge = 1'b0; integrate = 1'b1; end
            ST_REPORT:    res_valid  = 1'b1;
            ST_DONE:      sweep_done = 1'b1;
            default:      ;
        endcase
    end

    assign col_sel       = col_q;
    assign res_count     = count_q;
    assign res_col       = rcol_q;
    assign res_timeout   = tout_q;
    assign res_overrange = ovr_q;
endmodule

// File: rtl/tdc_seq_checker.sv
module tdc_seq_checker #(
    parameter int CNT_W            = 8,
    parameter int COL_W            = 3,
    parameter int DISCHARGE_CYCLES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count_max,
    input logic             res_ready,
    input logic [COL_W-1:0] col_sel,
    input logic             discharge,
    input logic             integrate,
    input logic             res_valid,
    input logic [CNT_W-1:0] res_count,
    input logic [COL_W-1:0] res_col,
    input logic             res_timeout,
    input logic             res_overrange,
    input logic             sweep_done
);
    int unsigned dis_run;

    always_ff @(posedge clk) begin
        if (rst || !discharge) dis_run <= 0;
        else                   dis_run <= dis_run + 1;
    end

    AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(discharge && integrate)); // R3
    AST_DISCHARGE_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $rose(integrate) |-> dis_run >= DISCHARGE_CYCLES); // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ready |=> res_valid && $stable(res_count) && $stable(res_col)
                                     && $stable(res_timeout) && $stable(res_overrange)); // R7
    AST_COL_HELD: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ready |=> $stable(col_sel)); // R7
    AST_OVERRANGE_ZERO: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_overrange |-> res_count == '0 && !res_timeout); // R5
    AST_TIMEOUT_AT_MAX: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_timeout |-> res_count == count_max); // R6
    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_count <= count_max); // R10
    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        sweep_done |-> $past(res_valid && res_ready)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sweep_done |=> !sweep_done); // R8
endmodule

bind tdc_column_sequencer tdc_seq_checker #(
    .CNT_W            (CNT_W),
    .COL_W            (COL_W),
    .DISCHARGE_CYCLES (DISCHARGE_CYCLES)
) i_seq_checker (
    .clk           (clk),
    .rst           (rst),
    .count_max     (count_max),
    .res_ready     (res_ready),
    .col_sel       (col_sel),
    .discharge     (discharge),
    .integrate     (integrate),
    .res_valid     (res_valid),
    .res_count     (res_count),
    .res_col       (res_col),
    .res_timeout   (res_timeout),
    .res_overrange (res_overrange),
    .sweep_done    (sweep_done)
);

// File: tb/test_tdc_column_sequencer.sv
module test_tdc_column_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NCOL  = 8;
    localparam int CW    = 8;
    localparam int DIS   = 4;
    localparam int COLW  = $clog2(NCOL);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [CW-1:0]   count_max = 8'd20;
    logic            cmp_async = 1'b0;
    logic            res_ready = 1'b0;
    logic [COLW-1:0] col_sel;
    logic            discharge;
    logic            integrate;
    logic            res_valid;
    logic [CW-1:0]   res_count;
    logic [COLW-1:0] res_col;
    logic            res_timeout;
    logic            res_overrange;
    logic            sweep_done;

    tdc_column_sequencer #(
        .NUM_COLS(NCOL), .CNT_W(CW), .DISCHARGE_CYCLES(DIS)
    ) i_tdc_column_sequencer (
        .clk(clk), .rst(rst), .start(start), .count_max(count_max),
        .cmp_async(cmp_async), .res_ready(res_ready), .col_sel(col_sel),
        .discharge(discharge), .integrate(integrate), .res_valid(res_valid),
        .res_count(res_count), .res_col(res_col), .res_timeout(res_timeout),
        .res_overrange(res_overrange), .sweep_done(sweep_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0, nerr = 0, cyc = 0;
    // behavioural reference: 0 idle, 1 discharge, 2 integrate, 3 report, 4 done
    int mph = 0, mcol = 0, mtimer = 0, mcyc = 0, mrise = -1, mwait = 0;
    int ecnt = 0, ecol = 0, eto = 0, eov = 0;
    int nres = 0, ndone = 0, sw = 0;
    bit start_req = 1'b0;
    bit full_scale_seen = 1'b0;

    function automatic int plan_of(int s, int c);
        int p0[NCOL] = '{0, 1, 5, 20, 21, -1, 3, 7};
        int p1[NCOL] = '{255, 100, 254, -1, 2, 256, 9, 0};
        if (s == 0) return p0[c];
        if (s == 1) return p1[c];
        return 4 + c;
    endfunction

    function automatic int rdelay(int c);
        int d[NCOL] = '{0, 2, 0, 5, 1, 0, 3, 0};
        return d[c];
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // reference model, advanced at every rising edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            mph = 0; mcol = 0;
        end else begin
            case (mph)
                0: if (start) begin mph = 1; mtimer = 0; end
                1: begin
                    mtimer++;
                    if (mtimer == DIS) begin mph = 2; mcyc = 0; mrise = -1; end
                end
                2: begin
                    if (cmp_async && mrise < 0) mrise = mcyc;
                    if (mrise >= 0 && mcyc == mrise + 2) begin
                        ecnt = mrise; eov = (mrise == 0); eto = 0; ecol = mcol;
                        mph = 3; mwait = 0;
                    end else if (mcyc == int'(count_max) + 2) begin
                        ecnt = int'(count_max); eov = 0; eto = 1; ecol = mcol;
                        mph = 3; mwait = 0;
                    end else mcyc++;
                end
                3: if (res_ready) begin
                    nres++;
                    if (sw == 1 && mcol == 0 && ecnt == 255 && eto == 0) full_scale_seen = 1'b1;
                    if (mcol == NCOL - 1) begin mph = 4; mcol = 0; end
                    else begin mcol++; mph = 1; mtimer = 0; end
                end else mwait++;
                4: begin mph = 0; ndone++; end
                default: mph = 0;
            endcase
        end
    end

    // stimulus and comparison, away from the rising edge
    always @(negedge clk) begin
        int p;
        p = plan_of(sw, mcol);
        cmp_async = (mph == 2 && p >= 0 && mcyc >= p);
        res_ready = (mph == 3 && mwait >= rdelay(mcol));
        // R9: start pulses inside integration and inside reporting
        start = start_req ||
                (sw == 0 && mph == 2 && mcol == 3 && mcyc == 2) ||
                (sw == 1 && mph == 3 && mcol == 1);
        start_req = 1'b0;
        if (!rst) begin
            chk("R2", "col_sel", 32'(col_sel), 32'(mcol));
            chk("R3", "discharge", 32'(discharge), 32'(mph != 2));
            chk("R3", "integrate", 32'(integrate), 32'(mph == 2));
            chk("R7", "res_valid", 32'(res_valid), 32'(mph == 3));
            chk("R8", "sweep_done", 32'(sweep_done), 32'(mph == 4));
            if (mph == 3) begin
                chk("R2", "res_col", 32'(res_col), 32'(ecol));
                chk("R4", "res_count", 32'(res_count), 32'(ecnt));
                chk("R5", "res_overrange", 32'(res_overrange), 32'(eov));
                chk("R6", "res_timeout", 32'(res_timeout), 32'(eto));
            end
        end
    end

    task automatic run_sweep(input int s, input logic [CW-1:0] cm);
        int r0, d0;
        @(posedge clk); #1;
        sw = s; count_max = cm; r0 = nres; d0 = ndone;
        start_req = 1'b1;
        while (ndone == d0) @(posedge clk);
        #1;
        chk("R9", "results per sweep", 32'(nres - r0), 32'(NCOL));
        chk("R9", "done pulses per sweep", 32'(ndone - d0), 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        chk("R1", "idle discharge", 32'(discharge), 32'd1);
        chk("R1", "idle integrate", 32'(integrate), 32'd0);
        chk("R1", "idle col_sel", 32'(col_sel), 32'd0);
        chk("R1", "idle res_valid", 32'(res_valid), 32'd0);

        run_sweep(0, 8'd20);
        run_sweep(1, 8'd255);
        chk("R10", "full-scale 255 result seen", 32'(full_scale_seen), 32'd1);

        // R1: reset in the middle of a sweep
        @(posedge clk); #1;
        sw = 2; count_max = 8'd12; start_req = 1'b1;
        while (!(mph == 2 && mcol == 2 && mcyc == 3)) @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk); #1;
        chk("R1", "mid-sweep reset integrate", 32'(integrate), 32'd0);
        chk("R1", "mid-sweep reset discharge", 32'(discharge), 32'd1);
        chk("R1", "mid-sweep reset col_sel", 32'(col_sel), 32'd0);
        chk("R1", "mid-sweep reset res_valid", 32'(res_valid), 32'd0);
        repeat (5) @(posedge clk);
        #1;
        chk("R9", "idle without start", 32'(integrate), 32'd0);

        run_sweep(2, 8'd12);
        repeat (3) @(posedge clk);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end
endmodule